// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This block sits between the inbound write path of an I/O translation unit and the interrupt fabric. For each interrupt-bearing request it receives the message address and data, together with the interrupt quadword of the originating device's table entry. It then chooses one of three outcomes. It can forward the message untouched. It can block the message with an error code. Or it can look up a 32-bit remap entry in memory and rewrite the message from that entry.

Ordinary memory writes fall outside the interrupt address window and leave unchanged. Special sources and special delivery modes may bypass remapping when the device entry grants them a pass bit. Fixed and lowest-priority interrupts follow a two-bit control field in the device entry. The block handles one request at a time. While a table read is outstanding it raises `busy` and ignores new requests. Every result appears as a one-cycle pulse on `res_valid`. The pulse carries the error code, a flag that says whether the error should be logged as an event, and the outgoing address and data.

Top module: `msi_remap_unit`

## Requirements
- R1: An MSI-source request (req_src = 0) whose address lies outside 0xFEE00000..0xFEEFFFFF is forwarded with address and data unchanged, error 0, and no table read.
- R2: For an in-window request with delivery mode data[10:8] equal to 0 or 1, device quadword bits 61:60 decide the outcome: 0 blocks with error 3 (target abort), 1 forwards unchanged, and 3 blocks with error 1 (generic).
- R3: When the control field is 2 and quadword bit 0 is clear, the request is forwarded unchanged. When bit 0 is set, exactly one table read is issued, at address {quadword[51:6], 6'b0} + 4 × data[10:0].
- R4: A valid, non-guest remap entry with a legal type produces a rewritten result with res_remapped = 1. The address is 0xFEE00000 | dest << 12 | dst_mode << 2 and the data is type << 8 | vector. The entry layout is: bit 0 valid, bit 1 no-fault, bits 4:2 type, bit 5 request-EOI, bit 6 destination mode, bit 7 guest mode, bits 15:8 destination, bits 23:16 vector. Data bits above 10 do not affect the table index.
- R5: A remap entry with valid clear gives error 1. Its report flag is the inverse of the entry's no-fault bit.
- R6: A remap entry with guest mode set, or with the reserved type 3 or 6, gives error 1 with report set.
- R7: A table read that returns an error gives error 2 (entry fetch failure) with report set.
- R8: In-window delivery modes other than 0 and 1 are handled as follows. Mode 7 (ExtINT) is forwarded unchanged if quadword bit 57 is set, otherwise error 1. Mode 4 (NMI) is forwarded if bit 58 is set, otherwise error 1. Modes 2, 3, 5 and 6 give error 1.
- R9: Local-pin sources skip the window check. req_src = 1 is forwarded if quadword bit 62 is set, otherwise error 1. req_src = 2 uses bit 63 in the same way. req_src = 3 gives error 1.
- R10: A result that needs no table read appears on res_valid one cycle after acceptance. A remapped result appears one cycle after the read response is sampled.
- R11: A request is accepted only while busy is low. Requests presented while busy is high produce neither a result nor a read.
- R12: On every blocked result, both address and data equal the original request. Report is set for every error except the no-fault case of R5, and report is never set together with error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | 2 | 0 message, 1 local pin 0, 2 local pin 1, 3 reserved |
| req_addr | input | 32 | Message address |
| req_data | input | 32 | Message data |
| dev_irq_qw | input | 64 | Interrupt quadword of the device table entry |
| busy | output | 1 | A table read is outstanding |
| mem_rd_req | output | 1 | One-cycle table read request |
| mem_rd_addr | output | ADDR_W | Byte address of the remap entry |
| mem_rd_valid | input | 1 | Read response present |
| mem_rd_err | input | 1 | Read response failed |
| mem_rd_data | input | 32 | Remap entry returned by memory |
| res_valid | output | 1 | One-cycle result pulse |
| res_remapped | output | 1 | Result was rewritten from a remap entry |
| res_err | output | 2 | 0 none, 1 generic, 2 fetch failure, 3 target abort |
| res_report | output | 1 | Error should be logged as an event |
| res_addr | output | 32 | Outgoing message address |
| res_data | output | 32 | Outgoing message data |

## Verification
A result that needs no table read is due on the cycle right after the accepting edge. A remapped result, or a failed read, is due L + 1 cycles after acceptance, where L is the response delay of the bench memory (1 to 3 cycles here). The bench records the exact due cycle when it drives each request. On every falling edge it compares res_valid and all result fields against a queue of predictions. A result that arrives early or late, or one nobody expected, counts as a miscompare. Each read request is checked for its address when it appears. The number of reads per request is checked once the request finishes.

// File: rtl/msi_remap_pkg.sv
// Package: msi_remap_pkg
// Shared types and field positions for the interrupt remapping unit.
// Bit positions listed here are decoded by neighbouring blocks and must
// stay fixed; everything else is local to the unit.
package msi_remap_pkg;

    // Result error codes seen by the event logger.
    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_GENERIC = 2'd1,
        ERR_FETCH   = 2'd2,
        ERR_TABORT  = 2'd3
    } err_e;

    // Outcome of the first-stage decision.
    typedef enum logic [1:0] {
        ACT_FORWARD = 2'd0,
        ACT_BLOCK   = 2'd1,
        ACT_FETCH   = 2'd2
    } act_e;

    // Origin of a request.
    typedef enum logic [1:0] {
        SRC_MSI   = 2'd0,
        SRC_LINT0 = 2'd1,
        SRC_LINT1 = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    // Delivery mode encodings carried in message data bits 10:8.
    localparam logic [2:0] DM_FIXED  = 3'd0;
    localparam logic [2:0] DM_ARB    = 3'd1;
    localparam logic [2:0] DM_SMI    = 3'd2;
    localparam logic [2:0] DM_NMI    = 3'd4;
    localparam logic [2:0] DM_INIT   = 3'd5;
    localparam logic [2:0] DM_EXTINT = 3'd7;

    // Control field values in the device quadword.
    localparam logic [1:0] CTL_ABORT = 2'd0;
    localparam logic [1:0] CTL_PASS  = 2'd1;
    localparam logic [1:0] CTL_REMAP = 2'd2;

    // Device quadword field positions.
    localparam int QW_REMAP_EN   = 0;
    localparam int QW_ROOT_LSB   = 6;
    localparam int QW_PASS_EXT   = 57;
    localparam int QW_PASS_NMI   = 58;
    localparam int QW_CTL_LSB    = 60;
    localparam int QW_PASS_LINT0 = 62;
    localparam int QW_PASS_LINT1 = 63;

    // Message field positions.
    localparam int MSI_MODE_LSB   = 8;
    localparam int MSI_DEST_LSB   = 12;
    localparam int MSI_DSTMODE_AT = 2;

    // 32-bit remap entry, most significant field first.
    typedef struct packed {
        logic [7:0] rsvd;
        logic [7:0] vector;
        logic [7:0] dest;
        logic       guest;
        logic       dst_mode;
        logic       rq_eoi;
        logic [2:0] itype;
        logic       no_fault;
        logic       valid;
    } irte_t;

endpackage

// File: rtl/msi_gate.sv
// Module: msi_gate
// First-stage decision for an interrupt request: forward, block or fetch
// a remap entry. Purely combinational.
// Assumes: addr_hi is the message address above the window size, mode is
// message data bits 10:8, and the pass/control inputs are slices of the
// device quadword.
module msi_gate
    import msi_remap_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFEE0_0000,
    parameter int          WIN_LOG2 = 20
) (
    input  src_e                 src,
    input  logic [31-WIN_LOG2:0] addr_hi,
    input  logic [2:0]           mode,
    input  logic [1:0]           ctl,
    input  logic                 remap_en,
    input  logic                 pass_extint,
    input  logic                 pass_nmi,
    input  logic                 pass_lint0,
    input  logic                 pass_lint1,
    output act_e                 act,
    output err_e                 err
);

    localparam logic [31-WIN_LOG2:0] WIN_TAG = WIN_BASE[31:WIN_LOG2];

    logic in_win;

    // Window match on the address bits above the window size.
    always_comb in_win = (addr_hi == WIN_TAG);

    // Source, window, delivery mode and control field, in priority order.
    always_comb begin
        act = ACT_FORWARD;
        err = ERR_NONE;
        case (src)
            SRC_LINT0: begin
                if (!pass_lint0) begin
                    act = ACT_BLOCK;
                    err = ERR_GENERIC;
                end
            end
            SRC_LINT1: begin
                if (!pass_lint1) begin
                    act = ACT_BLOCK;
                    err = ERR_GENERIC;
                end
            end
            SRC_RSVD: begin
                act = ACT_BLOCK;
                err = ERR_GENERIC;
            end
            default: begin
                if (in_win) begin
                    case (mode)
                        DM_FIXED, DM_ARB: begin
                            case (ctl)
                                CTL_ABORT: begin
                                    act = ACT_BLOCK;
                                    err = ERR_TABORT;
                                end
                                CTL_PASS: begin
                                    act = ACT_FORWARD;
                                end
                                CTL_REMAP: begin
                                    if (remap_en) act = ACT_FETCH;
                                end
                                default: begin
                                    act = ACT_BLOCK;
                                    err = ERR_GENERIC;
                                end
                            endcase
                        end
                        DM_NMI: begin
                            if (!pass_nmi) begin
                                act = ACT_BLOCK;
                                err = ERR_GENERIC;
                            end
                        end
                        DM_EXTINT: begin
                            if (!pass_extint) begin
                                act = ACT_BLOCK;
                                err = ERR_GENERIC;
                            end
                        end
                        default: begin
                            act = ACT_BLOCK;
                            err = ERR_GENERIC;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/msi_tbl_addr.sv
// Module: msi_tbl_addr
// Forms the byte address of a remap entry from the table root and the
// entry index. Combinational.
// Assumes: the root is aligned to 2**ROOT_LSB bytes and each entry is
// 2**ENTRY_LOG2 bytes wide.
module msi_tbl_addr #(
    parameter int ADDR_W     = 52,
    parameter int IDX_W      = 11,
    parameter int ENTRY_LOG2 = 2,
    parameter int ROOT_LSB   = 6
) (
    input  logic [ADDR_W-ROOT_LSB-1:0] root,
    input  logic [IDX_W-1:0]           idx,
    output logic [ADDR_W-1:0]          addr
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    // Re-align the root and scale the index to bytes.
    always_comb begin
        base = {root, {ROOT_LSB{1'b0}}};
        offs = ADDR_W'(idx) << ENTRY_LOG2;
    end

    // Entry address.
    always_comb addr = base + offs;

endmodule

// File: rtl/msi_irte_check.sv
// Module: msi_irte_check
// Validates a fetched remap entry and forms the rewritten message.
// Combinational.
// Assumes: raw is only meaningful while the read response is valid.
// The rewritten address carries the destination in bits 19:12.
module msi_irte_check
    import msi_remap_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFEE0_0000
) (
    input  logic [31:0] raw,
    input  logic        rd_err,
    output err_e        err,
    output logic        report,
    output logic [31:0] new_addr,
    output logic [31:0] new_data
);

    irte_t ent;
    logic  type_ok;
    logic  unused_ent;

    // View the raw word as an entry.
    always_comb ent = irte_t'(raw);

    // Request-EOI and reserved bits do not take part in this stage.
    always_comb unused_ent = ^{ent.rsvd, ent.rq_eoi};

    // Only defined delivery mode encodings are legal.
    always_comb type_ok = (ent.itype == DM_FIXED) || (ent.itype == DM_ARB) ||
                          (ent.itype == DM_SMI)   || (ent.itype == DM_NMI) ||
                          (ent.itype == DM_INIT)  || (ent.itype == DM_EXTINT);

    // Error classification; no-fault only silences the invalid-entry case.
    always_comb begin
        err    = ERR_NONE;
        report = 1'b0;
        if (rd_err) begin
            err    = ERR_FETCH;
            report = 1'b1;
        end else if (!ent.valid) begin
            err    = ERR_GENERIC;
            report = !ent.no_fault;
        end else if (ent.guest || !type_ok) begin
            err    = ERR_GENERIC;
            report = 1'b1;
        end
    end

    // Rewritten message address and data.
    always_comb begin
        new_addr = WIN_BASE | (32'(ent.dest) << MSI_DEST_LSB)
                            | (32'(ent.dst_mode) << MSI_DSTMODE_AT);
        new_data = 32'({ent.itype, ent.vector});
    end

endmodule

// File: rtl/msi_remap_unit.sv
// Module: msi_remap_unit (top)
// Interrupt remapping unit. Accepts one request while idle and decides it
// through msi_gate. A request that needs a remap entry issues a one-cycle
// read and waits for the response, which msi_irte_check then decodes.
// Every outcome leaves as a one-cycle res_valid pulse.
// Assumes: the memory answers each read exactly once, at least one cycle
// after the request, and raises mem_rd_valid only while a read is
// outstanding.
module msi_remap_unit
    import msi_remap_pkg::*;
#(
    parameter int          ADDR_W     = 52,
    parameter int          IDX_W      = 11,
    parameter int          ENTRY_LOG2 = 2,
    parameter logic [31:0] WIN_BASE   = 32'hFEE0_0000,
    parameter int          WIN_LOG2   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_src,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_data,
    input  logic [63:0]       dev_irq_qw,
    output logic              busy,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic              mem_rd_err,
    input  logic [31:0]       mem_rd_data,
    output logic              res_valid,
    output logic              res_remapped,
    output logic [1:0]        res_err,
    output logic              res_report,
    output logic [31:0]       res_addr,
    output logic [31:0]       res_data
);

    localparam int ROOT_W = ADDR_W - QW_ROOT_LSB;

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_e;

    state_e            state_q;
    act_e              gate_act;
    err_e              gate_err;
    err_e              chk_err;
    logic              chk_report;
    logic [31:0]       chk_addr;
    logic [31:0]       chk_data;
    logic [ADDR_W-1:0] tbl_addr;
    logic [31:0]       hold_addr_q;
    logic [31:0]       hold_data_q;
    logic              accept;
    logic              unused_qw;

    // Quadword bits not decoded by this unit.
    always_comb unused_qw = ^{dev_irq_qw[QW_CTL_LSB-1],
                              dev_irq_qw[QW_PASS_EXT-1:ADDR_W],
                              dev_irq_qw[QW_ROOT_LSB-1:1]};

    // A request is taken only while no read is outstanding.
    always_comb accept = req_valid && (state_q == ST_IDLE);
    always_comb busy   = (state_q == ST_WAIT);

    msi_gate #(
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) u_gate (
        .src         (src_e'(req_src)),
        .addr_hi     (req_addr[31:WIN_LOG2]),
        .mode        (req_data[MSI_MODE_LSB+2:MSI_MODE_LSB]),
        .ctl         (dev_irq_qw[QW_CTL_LSB+1:QW_CTL_LSB]),
        .remap_en    (dev_irq_qw[QW_REMAP_EN]),
        .pass_extint (dev_irq_qw[QW_PASS_EXT]),
        .pass_nmi    (dev_irq_qw[QW_PASS_NMI]),
        .pass_lint0  (dev_irq_qw[QW_PASS_LINT0]),
        .pass_lint1  (dev_irq_qw[QW_PASS_LINT1]),
        .act         (gate_act),
        .err         (gate_err)
    );

    msi_tbl_addr #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .ENTRY_LOG2 (ENTRY_LOG2),
        .ROOT_LSB   (QW_ROOT_LSB)
    ) u_tbl_addr (
        .root (dev_irq_qw[QW_ROOT_LSB+ROOT_W-1:QW_ROOT_LSB]),
        .idx  (req_data[IDX_W-1:0]),
        .addr (tbl_addr)
    );

    msi_irte_check #(
        .WIN_BASE (WIN_BASE)
    ) u_check (
        .raw      (mem_rd_data),
        .rd_err   (mem_rd_err),
        .err      (chk_err),
        .report   (chk_report),
        .new_addr (chk_addr),
        .new_data (chk_data)
    );

    // Sequencer: idle/wait state and the one-cycle read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            mem_rd_req <= 1'b0;
            if (accept && gate_act == ACT_FETCH) begin
                state_q     <= ST_WAIT;
                mem_rd_req  <= 1'b1;
                mem_rd_addr <= tbl_addr;
            end else if (state_q == ST_WAIT && mem_rd_valid) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Keep the original message for error results of a fetched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else if (accept) begin
            hold_addr_q <= req_addr;
            hold_data_q <= req_data;
        end
    end

    // Result register: direct outcomes on accept, fetched ones on response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_remapped <= 1'b0;
            res_err      <= ERR_NONE;
            res_report   <= 1'b0;
            res_addr     <= '0;
            res_data     <= '0;
        end else begin
            res_valid <= 1'b0;
            if (accept && gate_act != ACT_FETCH) begin
                res_valid    <= 1'b1;
                res_remapped <= 1'b0;
                res_err      <= gate_err;
                res_report   <= (gate_err != ERR_NONE);
                res_addr     <= req_addr;
                res_data     <= req_data;
            end else if (state_q == ST_WAIT && mem_rd_valid) begin
                res_valid    <= 1'b1;
                res_remapped <= (chk_err == ERR_NONE);
                res_err      <= chk_err;
                res_report   <= chk_report;
                res_addr     <= (chk_err == ERR_NONE) ? chk_addr : hold_addr_q;
                res_data     <= (chk_err == ERR_NONE) ? chk_data : hold_data_q;
            end
        end
    end

    // R11: no result leaves while a read is still outstanding.
    p_no_result_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && res_valid));

    // R3: a read request lasts one cycle and only happens while waiting.
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy ##1 !mem_rd_req);

    // R12: an event report always carries an error code.
    p_report_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_report) |-> (res_err != ERR_NONE));

    // R4: a rewritten message is error-free and lands in the window.
    p_remap_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_remapped) |->
            (res_err == ERR_NONE && res_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]));

    // R7: a fetch failure follows a failed read response.
    p_fetch_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err == ERR_FETCH) |-> $past(mem_rd_valid && mem_rd_err));

    // R10: a fetched result comes only from a sampled read response.
    p_remap_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_remapped) |-> $past(mem_rd_valid && busy));

endmodule

// File: tb/msi_remap_unit_tb.sv
// Bench for msi_remap_unit: behavioural prediction per request, a queue of
// expected results with due cycles, and a compare on every falling edge.
module msi_remap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_src = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [63:0] dev_irq_qw = '0;
    logic        busy;
    logic        mem_rd_req;
    logic [51:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic        mem_rd_err = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        res_valid;
    logic        res_remapped;
    logic [1:0]  res_err;
    logic        res_report;
    logic [31:0] res_addr;
    logic [31:0] res_data;

    always #2 clk = ~clk;

    msi_remap_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_src      (req_src),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .dev_irq_qw   (dev_irq_qw),
        .busy         (busy),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_err   (mem_rd_err),
        .mem_rd_data  (mem_rd_data),
        .res_valid    (res_valid),
        .res_remapped (res_remapped),
        .res_err      (res_err),
        .res_report   (res_report),
        .res_addr     (res_addr),
        .res_data     (res_data)
    );

    typedef struct {
        int          due;
        logic [1:0]  err;
        logic        rep;
        logic        rm;
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cur_lat = 1;
    int          rcnt = 0;
    int          rd_cnt = 0;
    logic [31:0] mem_word = '0;
    logic        mem_fail = 1'b0;
    logic [51:0] exp_taddr = '0;
    string       cur_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Memory model: checks the read address and answers after cur_lat cycles.
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        mem_rd_err   <= 1'b0;
        mem_rd_data  <= '0;
        if (rst_n && mem_rd_req) begin
            rd_cnt++;
            n_chk++;
            if (mem_rd_addr !== exp_taddr) begin
                n_bad++;
                $display("FAIL %s table address: got %h expected %h", cur_tag, mem_rd_addr, exp_taddr);
            end
            rcnt = cur_lat;
        end
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_err   <= mem_fail;
                mem_rd_data  <= mem_word;
            end
        end
    end

    // Compare outputs against the expected queue on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R11 unexpected result: got err=%0d a=%h d=%h expected none",
                             res_err, res_addr, res_data);
                end else begin
                    cur = q.pop_front();
                    if (cyc != cur.due || res_err !== cur.err || res_report !== cur.rep ||
                        res_remapped !== cur.rm || res_addr !== cur.a || res_data !== cur.d) begin
                        n_bad++;
                        $display("FAIL %s: got cyc=%0d err=%0d rep=%0b rm=%0b a=%h d=%h expected cyc=%0d err=%0d rep=%0b rm=%0b a=%h d=%h",
                                 cur.tag, cyc, res_err, res_report, res_remapped, res_addr, res_data,
                                 cur.due, cur.err, cur.rep, cur.rm, cur.a, cur.d);
                    end
                end
            end else if (q.size() != 0 && q[0].due == cyc) begin
                n_chk++;
                n_bad++;
                $display("FAIL %s R10 missing result: got res_valid=0 expected 1 at cycle %0d",
                         q[0].tag, cyc);
                void'(q.pop_front());
            end
        end
    end

    function automatic logic [63:0] mk_qw(input logic [1:0] ctl, input logic en,
                                          input logic [45:0] root, input logic p57,
                                          input logic p58, input logic p62, input logic p63);
        return {p63, p62, ctl, 1'b0, p58, p57, 5'b0, root, 5'b0, en};
    endfunction

    function automatic logic [31:0] mk_ent(input logic [7:0] vec, input logic [7:0] dest,
                                           input logic guest, input logic dm,
                                           input logic [2:0] ty, input logic nf, input logic v);
        return {8'h00, vec, dest, guest, dm, 1'b0, ty, nf, v};
    endfunction

    // Behavioural prediction from the requirements.
    function automatic void predict(input logic [1:0] src, input logic [31:0] a,
                                    input logic [31:0] d, input logic [63:0] qw,
                                    input logic [31:0] ent, input logic ferr,
                                    output exp_t e, output logic fetch,
                                    output logic [51:0] taddr);
        logic [2:0] mode;
        fetch = 1'b0;
        e.err = 2'd0;
        e.rm  = 1'b0;
        e.a   = a;
        e.d   = d;
        taddr = '0;
        mode  = d[10:8];
        if (src == 2'd1) begin
            if (!qw[62]) e.err = 2'd1;
        end else if (src == 2'd2) begin
            if (!qw[63]) e.err = 2'd1;
        end else if (src == 2'd3) begin
            e.err = 2'd1;
        end else if (a >= 32'hFEE0_0000 && a <= 32'hFEEF_FFFF) begin
            if (mode == 3'd0 || mode == 3'd1) begin
                if (qw[61:60] == 2'd0) e.err = 2'd3;
                else if (qw[61:60] == 2'd3) e.err = 2'd1;
                else if (qw[61:60] == 2'd2 && qw[0]) fetch = 1'b1;
            end else if (mode == 3'd4) begin
                if (!qw[58]) e.err = 2'd1;
            end else if (mode == 3'd7) begin
                if (!qw[57]) e.err = 2'd1;
            end else begin
                e.err = 2'd1;
            end
        end
        e.rep = (e.err != 2'd0);
        if (fetch) begin
            taddr = {qw[51:6], 6'b0} + 52'(d[10:0]) * 52'd4;
            if (ferr) begin
                e.err = 2'd2;
                e.rep = 1'b1;
            end else if (!ent[0]) begin
                e.err = 2'd1;
                e.rep = !ent[1];
            end else if (ent[7] || ent[4:2] == 3'd3 || ent[4:2] == 3'd6) begin
                e.err = 2'd1;
                e.rep = 1'b1;
            end else begin
                e.rm = 1'b1;
                e.a  = 32'hFEE0_0000 | (32'(ent[15:8]) << 12) | (32'(ent[6]) << 2);
                e.d  = (32'(ent[4:2]) << 8) | 32'(ent[23:16]);
            end
        end
    endfunction

    task automatic do_req(input string tag, input logic [1:0] src, input logic [31:0] a,
                          input logic [31:0] d, input logic [63:0] qw, input logic [31:0] ent,
                          input logic ferr, input int lat);
        exp_t        e;
        logic        fetch;
        logic [51:0] taddr;
        int          rd0;
        @(negedge clk);
        predict(src, a, d, qw, ent, ferr, e, fetch, taddr);
        e.tag     = tag;
        e.due     = cyc + 1 + (fetch ? lat : 0);
        exp_taddr = taddr;
        mem_word  = ent;
        mem_fail  = ferr;
        cur_lat   = lat;
        cur_tag   = tag;
        rd0       = rd_cnt;
        q.push_back(e);
        req_valid  = 1'b1;
        req_src    = src;
        req_addr   = a;
        req_data   = d;
        dev_irq_qw = qw;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        n_chk++;
        if (rd_cnt - rd0 != (fetch ? 1 : 0)) begin
            n_bad++;
            $display("FAIL %s R3 read count: got %0d expected %0d", tag, rd_cnt - rd0, fetch ? 1 : 0);
        end
    endtask

    localparam logic [45:0] ROOT = 46'h0_1234_5678_9A;

    initial begin
        exp_t e;
        logic fetch;
        logic [51:0] taddr;
        int rd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b0 || res_valid !== 1'b0 || mem_rd_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset state: got busy=%0b valid=%0b rd=%0b expected 0 0 0",
                     busy, res_valid, mem_rd_req);
        end

        // R1: outside the window, below and just above
        do_req("R1", 2'd0, 32'h1000_0040, 32'h0000_0031, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0), '0, 0, 1);
        do_req("R1", 2'd0, 32'hFEF0_0000, 32'h0000_0031, mk_qw(2'd0, 1, ROOT, 0, 0, 0, 0), '0, 0, 1);
        // R2: control field outcomes, top of window
        do_req("R2", 2'd0, 32'hFEEF_FFFC, 32'h0000_0020, mk_qw(2'd0, 1, ROOT, 0, 0, 0, 0), '0, 0, 1);
        do_req("R2", 2'd0, 32'hFEE0_1000, 32'h0000_0120, mk_qw(2'd1, 1, ROOT, 0, 0, 0, 0), '0, 0, 1);
        do_req("R2", 2'd0, 32'hFEE0_1000, 32'h0000_0020, mk_qw(2'd3, 1, ROOT, 0, 0, 0, 0), '0, 0, 1);
        // R3: remap disabled forwards
        do_req("R3", 2'd0, 32'hFEE0_0000, 32'h0000_0055, mk_qw(2'd2, 0, ROOT, 0, 0, 0, 0), '0, 0, 1);
        // R4: rewrite with short and long read latency, upper data bits set
        do_req("R4", 2'd0, 32'hFEE0_0000, 32'h0000_0033, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 1, 3'd1, 0, 1), 0, 1);
        do_req("R4", 2'd0, 32'hFEE0_F00C, 32'hABCD_01FF, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'hEE, 8'hFF, 0, 0, 3'd0, 0, 1), 0, 3);
        do_req("R4", 2'd0, 32'hFEE0_0000, 32'h0000_0000, mk_qw(2'd2, 1, 46'h3FFF_FFFF_FFFF, 0, 0, 0, 0),
               mk_ent(8'h10, 8'h01, 0, 0, 3'd7, 1, 1), 0, 2);
        // R5: invalid entry, with and without no-fault
        do_req("R5", 2'd0, 32'hFEE0_0000, 32'h0000_0007, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 1, 3'd1, 0, 0), 0, 2);
        do_req("R5", 2'd0, 32'hFEE0_0000, 32'h0000_0008, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 1, 3'd1, 1, 0), 0, 1);
        // R6: guest mode and reserved type
        do_req("R6", 2'd0, 32'hFEE0_0000, 32'h0000_0009, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 1, 0, 3'd0, 0, 1), 0, 1);
        do_req("R6", 2'd0, 32'hFEE0_0000, 32'h0000_000A, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 0, 3'd3, 0, 1), 0, 1);
        do_req("R6", 2'd0, 32'hFEE0_0000, 32'h0000_000B, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 0, 3'd6, 1, 1), 0, 1);
        // R7: read failure
        do_req("R7", 2'd0, 32'hFEE0_0000, 32'h0000_000C, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
               mk_ent(8'h41, 8'h23, 0, 0, 3'd0, 1, 1), 1, 2);
        // R8: special delivery modes
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0700, mk_qw(2'd2, 1, ROOT, 1, 0, 0, 0), '0, 0, 1);
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0700, mk_qw(2'd2, 1, ROOT, 0, 1, 1, 1), '0, 0, 1);
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0400, mk_qw(2'd1, 1, ROOT, 0, 1, 0, 0), '0, 0, 1);
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0400, mk_qw(2'd1, 1, ROOT, 1, 0, 0, 0), '0, 0, 1);
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0200, mk_qw(2'd1, 1, ROOT, 1, 1, 1, 1), '0, 0, 1);
        do_req("R8", 2'd0, 32'hFEE0_0000, 32'h0000_0500, mk_qw(2'd1, 1, ROOT, 1, 1, 1, 1), '0, 0, 1);
        // R9: local pin sources
        do_req("R9", 2'd1, 32'h0000_0000, 32'h0000_0001, mk_qw(2'd0, 0, ROOT, 0, 0, 1, 0), '0, 0, 1);
        do_req("R9", 2'd1, 32'hFEE0_0000, 32'h0000_0001, mk_qw(2'd1, 0, ROOT, 0, 0, 0, 1), '0, 0, 1);
        do_req("R9", 2'd2, 32'h0000_0000, 32'h0000_0002, mk_qw(2'd0, 0, ROOT, 0, 0, 0, 1), '0, 0, 1);
        do_req("R9", 2'd3, 32'hFEE0_0000, 32'h0000_0003, mk_qw(2'd1, 1, ROOT, 1, 1, 1, 1), '0, 0, 1);
        do_req("R12", 2'd0, 32'hFEE0_0010, 32'hFFFF_0022, mk_qw(2'd0, 1, ROOT, 1, 1, 1, 1), '0, 0, 1);

        // R11: requests held while busy are ignored
        @(negedge clk);
        predict(2'd0, 32'hFEE0_0000, 32'h0000_0011, mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0),
                mk_ent(8'h77, 8'h05, 0, 1, 3'd0, 0, 1), 0, e, fetch, taddr);
        e.tag     = "R11";
        e.due     = cyc + 1 + 3;
        exp_taddr = taddr;
        mem_word  = mk_ent(8'h77, 8'h05, 0, 1, 3'd0, 0, 1);
        mem_fail  = 1'b0;
        cur_lat   = 3;
        cur_tag   = "R11";
        rd0       = rd_cnt;
        q.push_back(e);
        req_valid  = 1'b1;
        req_src    = 2'd0;
        req_addr   = 32'hFEE0_0000;
        req_data   = 32'h0000_0011;
        dev_irq_qw = mk_qw(2'd2, 1, ROOT, 0, 0, 0, 0);
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 busy: got %0b expected 1", busy);
        end
        req_addr   = 32'h2000_0000;
        req_data   = 32'h0000_0099;
        dev_irq_qw = mk_qw(2'd1, 0, ROOT, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        n_chk++;
        if (rd_cnt - rd0 != 1 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reads while busy: got %0d busy=%0b expected 1 busy=0", rd_cnt - rd0, busy);
        end

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule